// File: doc/BRIEF.md
# Network Interrupt Aggregation Registers

This block gathers interrupt requests raised by network interfaces and presents them to a CPU as two 16-bit active-low status words, plus one combined interrupt line. The built-in ports of the base board (slot 0) occupy the low byte of the first status word. Each of four plug-in module slots owns one nibble of the second status word. Hardware raises a request with a one-cycle set strobe for a given slot and port, which drives the matching bit to 0. A clear strobe returns that bit to 1.

The CPU reaches the block over a simple 16-bit register bus with combinational read data. The bus also carries two read/write mask words, which are storage only and do not gate the interrupt. There are two read-only presence words built from active-low input flags: one for module slots and one for flash cards. A handful of fixed constant words are also readable. Every other offset reads as zero.

Top module: `net_irq_regs`

## Requirements
- R1: After reset, offsets 0x20 and 0x22 read 0xFFFF, the mask words at 0x2A and 0x2C read 0x0000, and `irq_o` is low.
- R2: A set strobe drives its status bit to 0. A later clear strobe for the same bit restores it to 1.
- R3: A strobe on `s0_set_i[p]` or `s0_clr_i[p]` acts on bit p of offset 0x20, for p from 0 to 7. Bits 15..8 of 0x20 always read 1.
- R4: Strobe index 4*(k-1)+p of `nm_set_i` or `nm_clr_i` stands for module slot k (1..4) and port p (0..3). It acts on bit 4*(k-1)+p of offset 0x22.
- R5: When a set and a clear hit the same bit in one cycle, the bit ends at 1. Strobes to different bits in the same cycle all take effect.
- R6: `irq_o` is registered. It is high one clock after either status word differs from 0xFFFF, and low one clock after both words are back to 0xFFFF.
- R7: Bus writes to 0x20 and 0x22 have no effect on the status words.
- R8: Offsets 0x2A and 0x2C are independent 16-bit read/write words that return the value last written to them.
- R9: Offset 0x4E reads 0xFFFF with every bit of `nm_present_ni` high. A low `nm_present_ni[k-1]` for slot k clears one bit: slot 1 clears bit 8, slot 2 clears bit 0, slot 3 clears bit 12 and slot 4 clears bit 4.
- R10: Offset 0x12 reads 0xFFFF by default. A low `flash_sys_ni` clears bit 1, and a low `flash_s0_ni` clears bit 0.
- R11: Offsets 0x00, 0x04, 0x48 and 0x4A read 0xFFFF. Offset 0x14 reads 0x00FF. Offsets 0x0A and 0x0C read 0x0000. Any unlisted offset reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s0_set_i | input | 8 | Raise request, slot 0 port p |
| s0_clr_i | input | 8 | Drop request, slot 0 port p |
| nm_set_i | input | 16 | Raise request, module slot/port |
| nm_clr_i | input | 16 | Drop request, module slot/port |
| nm_present_ni | input | 4 | Module present flags, active low, index 0 = slot 1 |
| flash_sys_ni | input | 1 | System flash card present, active low |
| flash_s0_ni | input | 1 | Slot-0 flash card present, active low |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Combined network interrupt |

## Verification
The bench builds the block with its default shape: eight slot-0 ports and four module slots of four ports each. With that shape the top mapped bit of both status words can be reached, along with the fixed-high upper byte of the slot-0 word. The bench checks `irq_o` in the cycle just after a status change, while it still holds its old value, and again one cycle later. It also applies a combined set and clear strobe in the same cycle, mixing a colliding bit with a separate bit.

// File: rtl/net_irq_pkg.sv
package net_irq_pkg;
  localparam int unsigned REG_W = 16;

  localparam logic [7:0] OFF_STAT0  = 8'h20;
  localparam logic [7:0] OFF_STAT1  = 8'h22;
  localparam logic [7:0] OFF_MASK0  = 8'h2A;
  localparam logic [7:0] OFF_MASK1  = 8'h2C;
  localparam logic [7:0] OFF_NMPRES = 8'h4E;
  localparam logic [7:0] OFF_FLASH  = 8'h12;
  localparam logic [7:0] OFF_ONE_A  = 8'h00;
  localparam logic [7:0] OFF_ONE_B  = 8'h04;
  localparam logic [7:0] OFF_ONE_C  = 8'h48;
  localparam logic [7:0] OFF_ONE_D  = 8'h4A;
  localparam logic [7:0] OFF_LOWB   = 8'h14;
  localparam logic [7:0] OFF_ZERO_A = 8'h0A;
  localparam logic [7:0] OFF_ZERO_B = 8'h0C;

  localparam int unsigned NUM_MASK = 2;
  localparam logic [7:0] MASK_OFF [NUM_MASK] = '{OFF_MASK0, OFF_MASK1};

  // presence bit cleared by module slot k (index k-1); scattered by design
  localparam int unsigned NM_SLOTS = 4;
  localparam int unsigned NM_PRES_BIT [NM_SLOTS] = '{8, 0, 12, 4};

  localparam int unsigned FLASH_SYS_BIT = 1;
  localparam int unsigned FLASH_S0_BIT  = 0;
endpackage

// File: rtl/net_irq_status.sv
module net_irq_status #(
  parameter int unsigned W      = 16,
  parameter int unsigned GROUPS = 1,
  parameter int unsigned PORTS  = 8,
  parameter int unsigned STRIDE = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [GROUPS*PORTS-1:0]   set_i,
  input  logic [GROUPS*PORTS-1:0]   clr_i,
  output logic [W-1:0]              stat_o,
  output logic                      pend_o
);
  logic [W-1:0] q, d;

  for (genvar b = 0; b < W; b++) begin : g_bit
    localparam int unsigned GI = b / STRIDE;
    localparam int unsigned PI = b % STRIDE;
    if (GI < GROUPS && PI < PORTS) begin : g_map
      // drop request dominates a simultaneous raise
      assign d[b] = clr_i[GI*PORTS+PI] ? 1'b1
                  : (set_i[GI*PORTS+PI] ? 1'b0 : q[b]);
    end else begin : g_fix
      assign d[b] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= d;
  end

  assign stat_o = q;
  assign pend_o = ~&q;
endmodule

// File: rtl/net_irq_mask_regs.sv
module net_irq_mask_regs
  import net_irq_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [7:0]                    addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [NUM_MASK-1:0][DW-1:0]   mask_o
);
  for (genvar i = 0; i < NUM_MASK; i++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mask_o[i] <= '0;
      else if (wr_i && addr_i == MASK_OFF[i]) mask_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/net_irq_rdmux.sv
module net_irq_rdmux
  import net_irq_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic [7:0]                    addr_i,
  input  logic [DW-1:0]                 stat0_i,
  input  logic [DW-1:0]                 stat1_i,
  input  logic [NUM_MASK-1:0][DW-1:0]   mask_i,
  input  logic [NM_SLOTS-1:0]           nm_present_ni,
  input  logic                          flash_sys_ni,
  input  logic                          flash_s0_ni,
  output logic [DW-1:0]                 rdata_o
);
  localparam int unsigned HALF = DW / 2;
  logic [DW-1:0] pres_w, flash_w;

  always_comb begin
    pres_w = '1;
    for (int k = 0; k < NM_SLOTS; k++) pres_w[NM_PRES_BIT[k]] = nm_present_ni[k];
    flash_w = '1;
    flash_w[FLASH_SYS_BIT] = flash_sys_ni;
    flash_w[FLASH_S0_BIT]  = flash_s0_ni;
  end

  always_comb begin
    unique case (addr_i)
      OFF_STAT0:  rdata_o = stat0_i;
      OFF_STAT1:  rdata_o = stat1_i;
      OFF_MASK0:  rdata_o = mask_i[0];
      OFF_MASK1:  rdata_o = mask_i[1];
      OFF_NMPRES: rdata_o = pres_w;
      OFF_FLASH:  rdata_o = flash_w;
      OFF_ONE_A, OFF_ONE_B, OFF_ONE_C, OFF_ONE_D: rdata_o = '1;
      OFF_LOWB:   rdata_o = {{(DW-HALF){1'b0}}, {HALF{1'b1}}};
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/net_irq_regs.sv
module net_irq_regs
  import net_irq_pkg::*;
#(
  parameter int unsigned S0_PORTS = 8,
  parameter int unsigned NM_PORTS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [S0_PORTS-1:0]           s0_set_i,
  input  logic [S0_PORTS-1:0]           s0_clr_i,
  input  logic [NM_SLOTS*NM_PORTS-1:0]  nm_set_i,
  input  logic [NM_SLOTS*NM_PORTS-1:0]  nm_clr_i,
  input  logic [NM_SLOTS-1:0]           nm_present_ni,
  input  logic                          flash_sys_ni,
  input  logic                          flash_s0_ni,
  input  logic [7:0]                    bus_addr_i,
  input  logic                          bus_wr_i,
  input  logic [REG_W-1:0]              bus_wdata_i,
  output logic [REG_W-1:0]              bus_rdata_o,
  output logic                          irq_o
);
  logic [REG_W-1:0] stat0_q, stat1_q;
  logic             pend0, pend1, irq_q;
  logic [NUM_MASK-1:0][REG_W-1:0] mask_q;

  net_irq_status #(.W(REG_W), .GROUPS(1), .PORTS(S0_PORTS), .STRIDE(S0_PORTS)) u_stat0 (
    .clk_i, .rst_ni, .set_i(s0_set_i), .clr_i(s0_clr_i), .stat_o(stat0_q), .pend_o(pend0)
  );

  net_irq_status #(.W(REG_W), .GROUPS(NM_SLOTS), .PORTS(NM_PORTS), .STRIDE(NM_PORTS)) u_stat1 (
    .clk_i, .rst_ni, .set_i(nm_set_i), .clr_i(nm_clr_i), .stat_o(stat1_q), .pend_o(pend1)
  );

  net_irq_mask_regs #(.DW(REG_W)) u_mask (
    .clk_i, .rst_ni, .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .mask_o(mask_q)
  );

  net_irq_rdmux #(.DW(REG_W)) u_rd (
    .addr_i(bus_addr_i), .stat0_i(stat0_q), .stat1_i(stat1_q), .mask_i(mask_q),
    .nm_present_ni, .flash_sys_ni, .flash_s0_ni, .rdata_o(bus_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pend0 | pend1;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/net_irq_regs_chk.sv
module net_irq_regs_chk
  import net_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        s0_set_i,
  input logic [7:0]        s0_clr_i,
  input logic [15:0]       nm_set_i,
  input logic [15:0]       nm_clr_i,
  input logic              bus_wr_i,
  input logic [7:0]        bus_addr_i,
  input logic [REG_W-1:0]  stat0,
  input logic [REG_W-1:0]  stat1,
  input logic [REG_W-1:0]  mask0,
  input logic              irq_o
);
  assert_clr_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s0_clr_i[0] |=> stat0[0]);

  assert_set_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s0_set_i[0] && !s0_clr_i[0]) |=> !stat0[0]);

  assert_nm_map_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nm_set_i[4] && !nm_clr_i[4]) |=> !stat1[4]);

  assert_s0_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat0[15:8] == 8'hFF);

  assert_irq_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat0 != '1 || stat1 != '1) |=> irq_o);

  assert_irq_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat0 == '1 && stat1 == '1) |=> !irq_o);

  assert_stat_ro_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|s0_set_i) && !(|s0_clr_i) && !(|nm_set_i) && !(|nm_clr_i)) |=> ($stable(stat0) && $stable(stat1)));

  assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && bus_addr_i == OFF_MASK0) |=> $stable(mask0));
endmodule

bind net_irq_regs net_irq_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .s0_set_i(s0_set_i), .s0_clr_i(s0_clr_i), .nm_set_i(nm_set_i), .nm_clr_i(nm_clr_i),
  .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .stat0(stat0_q), .stat1(stat1_q), .mask0(mask_q[0]), .irq_o(irq_o)
);

// File: tb/net_irq_regs_test.sv
module net_irq_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  s0_set_i = '0, s0_clr_i = '0;
  logic [15:0] nm_set_i = '0, nm_clr_i = '0;
  logic [3:0]  nm_present_ni = '1;
  logic        flash_sys_ni = 1'b1, flash_s0_ni = 1'b1;
  logic [7:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        irq_o;

  always #2.5 clk_i = ~clk_i;

  net_irq_regs uut (.*);

  typedef struct { bit is_irq; logic [15:0] exp; string tag; } item_t;
  item_t sb[$];
  logic probe = 1'b0;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always @(negedge clk_i) begin : mon
    item_t it;
    logic [15:0] act;
    if (probe && sb.size() > 0) begin
      it  = sb.pop_front();
      act = it.is_irq ? {15'b0, irq_o} : bus_rdata_o;
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got 0x%04h expected 0x%04h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk_rd(input logic [7:0] a, input logic [15:0] e, input string t);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = t;
    bus_addr_i = a; sb.push_back(it); probe = 1'b1;
    @(posedge clk_i); #1 probe = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    item_t it;
    it.is_irq = 1'b1; it.exp = {15'b0, e}; it.tag = t;
    sb.push_back(it); probe = 1'b1;
    @(posedge clk_i); #1 probe = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(posedge clk_i); #1 bus_wr_i = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] ss, input logic [7:0] sc,
                       input logic [15:0] ns, input logic [15:0] nc);
    s0_set_i = ss; s0_clr_i = sc; nm_set_i = ns; nm_clr_i = nc;
    @(posedge clk_i); #1;
    s0_set_i = '0; s0_clr_i = '0; nm_set_i = '0; nm_clr_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    chk_rd(8'h20, 16'hFFFF, "R1 stat0 reset");
    chk_rd(8'h22, 16'hFFFF, "R1 stat1 reset");
    chk_rd(8'h2A, 16'h0000, "R1 mask0 reset");
    chk_rd(8'h2C, 16'h0000, "R1 mask1 reset");
    chk_irq(1'b0, "R1 irq reset");

    chk_rd(8'h00, 16'hFFFF, "R11 0x00");
    chk_rd(8'h04, 16'hFFFF, "R11 0x04");
    chk_rd(8'h48, 16'hFFFF, "R11 0x48");
    chk_rd(8'h4A, 16'hFFFF, "R11 0x4A");
    chk_rd(8'h14, 16'h00FF, "R11 0x14");
    chk_rd(8'h0A, 16'h0000, "R11 0x0A");
    chk_rd(8'h0C, 16'h0000, "R11 0x0C");
    chk_rd(8'h7E, 16'h0000, "R11 unknown");

    chk_rd(8'h12, 16'hFFFF, "R10 flash none");
    flash_sys_ni = 1'b0;
    chk_rd(8'h12, 16'hFFFD, "R10 flash sys");
    flash_s0_ni = 1'b0;
    chk_rd(8'h12, 16'hFFFC, "R10 flash both");

    chk_rd(8'h4E, 16'hFFFF, "R9 none");
    nm_present_ni = 4'b1110; chk_rd(8'h4E, 16'hFEFF, "R9 slot1");
    nm_present_ni = 4'b1101; chk_rd(8'h4E, 16'hFFFE, "R9 slot2");
    nm_present_ni = 4'b1011; chk_rd(8'h4E, 16'hEFFF, "R9 slot3");
    nm_present_ni = 4'b0111; chk_rd(8'h4E, 16'hFFEF, "R9 slot4");
    nm_present_ni = 4'b0000; chk_rd(8'h4E, 16'hEEEE, "R9 all");

    wr(8'h2A, 16'h1234);
    chk_rd(8'h2A, 16'h1234, "R8 mask0");
    wr(8'h2C, 16'hBEEF);
    chk_rd(8'h2C, 16'hBEEF, "R8 mask1");
    wr(8'h2A, 16'h00A5);
    chk_rd(8'h2C, 16'hBEEF, "R8 mask1 kept");
    chk_rd(8'h2A, 16'h00A5, "R8 mask0 rewrite");
    chk_irq(1'b0, "R6 masks do not raise irq");

    pulse(8'h08, 8'h00, 16'h0000, 16'h0000);
    chk_irq(1'b0, "R6 irq one-cycle latency");
    chk_rd(8'h20, 16'hFFF7, "R3 slot0 port3 set");
    chk_irq(1'b1, "R6 irq high");
    pulse(8'h80, 8'h00, 16'h0000, 16'h0000);
    chk_rd(8'h20, 16'hFF77, "R3 slot0 port7");
    pulse(8'h00, 8'h88, 16'h0000, 16'h0000);
    chk_rd(8'h20, 16'hFFFF, "R2 slot0 cleared");
    chk_irq(1'b0, "R6 irq low");

    pulse(8'h00, 8'h00, 16'h0200, 16'h0000);
    chk_rd(8'h22, 16'hFDFF, "R4 slot3 port1");
    pulse(8'h00, 8'h00, 16'h8000, 16'h0000);
    chk_rd(8'h22, 16'h7DFF, "R4 slot4 port3");
    chk_irq(1'b1, "R6 irq from stat1");
    wr(8'h22, 16'hFFFF);
    chk_rd(8'h22, 16'h7DFF, "R7 stat1 write ignored");
    wr(8'h20, 16'h0000);
    chk_rd(8'h20, 16'hFFFF, "R7 stat0 write ignored");
    pulse(8'h00, 8'h00, 16'h0000, 16'h8200);
    chk_rd(8'h22, 16'hFFFF, "R2 stat1 cleared");
    chk_irq(1'b0, "R6 irq low again");

    pulse(8'h24, 8'h04, 16'h0010, 16'h0000);
    chk_rd(8'h20, 16'hFFDF, "R5 clear wins, other bit set");
    chk_rd(8'h22, 16'hFFEF, "R5 same-cycle nm bit");
    pulse(8'h00, 8'h20, 16'h0000, 16'h0010);
    chk_rd(8'h20, 16'hFFFF, "R5 stat0 restored");
    chk_irq(1'b0, "R6 irq final");

    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule